// File: doc/BRIEF.md
# Spread-Spectrum PWM Generator

This block drives a single logic-level gate signal for a switching power stage. The duty ratio is fixed by an 8-bit input. In randomized mode, the length of each switching period is chosen anew at every period boundary. The new length is a base count plus a scaled value from a 12-bit pseudorandom shift register. This spreads the switching energy over a band of frequencies instead of concentrating it in one line.

The on time is recomputed from the new period and the sampled duty input, so the average duty ratio does not move. In fixed mode, the period stays at the nominal count: 500 cycles of a 50 MHz clock, which is 100 kHz.

Period, on time, pseudorandom advance and input sampling all happen on one clock edge, the reload edge. A period therefore never mixes two settings. With the default parameters, a randomized period spans 375 to 749 clocks, which is about 66.8 to 133 kHz. That keeps the switching frequency within one third of the nominal value on either side.

Top module: `rand_period_pwm`

## Requirements
- R1: A synchronous active-low reset forces the output low, loads the seed, and sets the cycle count to 1. The period that starts when reset is released is 500 clocks long with zero on time, so the output stays low for those 500 clocks.
- R2: Every period of P clocks consists of H clocks high followed by P−H clocks low. The high part comes first.
- R3: The on time is H = floor(P × D / 256), where D is the 8-bit duty input and P is the length of that same period.
- R4: Duty and mode are sampled only on the reload edge, which is the edge on which the count equals the current period. Changes at any other time have no effect on the period in progress.
- R5: When the mode input is 0 at the reload edge, the next period is exactly 500 clocks.
- R6: When the mode input is 1 at the reload edge, the next period is 375 + floor(L × 375 / 4096). L is the shift-register state just before that edge's advance.
- R7: The shift register is 12 bits wide. It is loaded with 12'h5A5 on reset. On every reload edge, whatever the mode, it advances to {L[10:0], L[11]^L[5]^L[3]^L[0]}. It holds its value on all other edges.
- R8: A randomized period always lies between 375 and 749 clocks inclusive.
- R9: Duty 0 keeps the output low for the whole period. Duty 255 leaves it low for only P − floor(P × 255 / 256) clocks at the end of the period.
- R10: The shift register never reaches the all-zero state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 50 MHz nominal |
| rst_n | input | 1 | Synchronous reset, active low |
| duty_i | input | 8 | Duty ratio in 1/256 steps, sampled at the reload edge |
| rand_mode_i | input | 1 | 1 selects randomized period, 0 selects fixed 500-clock period |
| pwm_o | output | 1 | Gate drive waveform at logic level |

## Verification
The hold and fixed-period properties assume that duty and mode are stable only around the reload edge. They assume nothing about what happens in the middle of a period. To exercise that, the stimulus inverts both inputs early in every period and writes the real values back only halfway through. The properties also assume that reset is held for at least one edge before any checking. The stimulus holds reset for three clocks, both at start-up and when reset is reapplied in the middle of a run.

// File: rtl/prpwm_pkg.sv
// Shared constants and types for the spread-spectrum PWM generator.
// Assumes a 50 MHz clock, so a 500-count period is 100 kHz.
package prpwm_pkg;
    localparam int          LFSR_W   = 12;
    localparam logic [11:0] LFSR_TAP = 12'h829;   // bits 11, 5, 3, 0
    localparam logic [11:0] LFSR_SEED = 12'h5A5;
    localparam int          NOM_CNT  = 500;
    localparam int          BASE_CNT = 375;
    localparam int          SPAN_CNT = 375;
    localparam int          DUTY_W   = 8;
    localparam int          PER_W    = $clog2(BASE_CNT + SPAN_CNT + 1);
endpackage

// File: rtl/prpwm_lfsr.sv
// Fibonacci shift register that moves toward the MSB, with the feedback
// bit being the XOR of the tapped bits.
// Steps only when adv_i is high. Assumes SEED is non-zero.
module prpwm_lfsr #(
    parameter int         W    = 12,
    parameter logic [W-1:0] TAPS = 12'h829,
    parameter logic [W-1:0] SEED = 12'h5A5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv_i,
    output logic [W-1:0] state_o
);
    logic [W-1:0] sr_q;
    logic         fb;

    // feedback: parity of the tapped bits
    assign fb = ^(sr_q & TAPS);

    // state register: seed on reset, shift left on each advance
    always_ff @(posedge clk) begin
        if (!rst_n)     sr_q <= SEED;
        else if (adv_i) sr_q <= {sr_q[W-2:0], fb};
    end

    assign state_o = sr_q;

    p_nonzero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sr_q != '0);

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> $stable(sr_q));
endmodule

// File: rtl/prpwm_period.sv
// Picks the next switching period length. In randomized mode it is the
// base plus the shift-register value scaled into [0, SPAN). In fixed
// mode it is the nominal count. Purely combinational.
module prpwm_period #(
    parameter int LW    = 12,
    parameter int PW    = 10,
    parameter int NOM   = 500,
    parameter int BASE  = 375,
    parameter int SPAN  = 375
) (
    input  logic [LW-1:0] lfsr_i,
    input  logic          rand_i,
    output logic [PW-1:0] period_o
);
    localparam int SPAN_W = (SPAN > 1) ? $clog2(SPAN + 1) : 1;
    localparam int PROD_W = LW + SPAN_W;

    logic [PW-1:0] rand_per;

    generate
        if (SPAN > 0) begin : g_spread
            logic [PROD_W-1:0] prod;
            // scale: lfsr * SPAN / 2^LW
            always_comb begin
                prod     = PROD_W'(lfsr_i) * PROD_W'(SPAN);
                rand_per = PW'(BASE) + PW'(prod[LW +: SPAN_W]);
            end
        end else begin : g_flat
            logic unused_lfsr;
            // no spread: randomized mode collapses onto the base
            assign unused_lfsr = ^lfsr_i;
            assign rand_per    = PW'(BASE);
        end
    endgenerate

    // mode select between randomized and nominal period
    assign period_o = rand_i ? rand_per : PW'(NOM);
endmodule

// File: rtl/prpwm_ontime.sv
// Computes the on time as floor(period * duty / 2^DW) for a fixed
// duty ratio. Purely combinational. The result never exceeds period.
module prpwm_ontime #(
    parameter int PW = 10,
    parameter int DW = 8
) (
    input  logic [PW-1:0] period_i,
    input  logic [DW-1:0] duty_i,
    output logic [PW-1:0] on_o
);
    localparam int PROD_W = PW + DW;

    logic [PROD_W-1:0] prod;

    // multiply and drop the duty fraction bits
    always_comb begin
        prod = PROD_W'(period_i) * PROD_W'(duty_i);
        on_o = prod[DW +: PW];
    end
endmodule

// File: rtl/rand_period_pwm.sv
// Spread-spectrum PWM top level. A cycle counter runs from 1 up to the
// current period. On the reload edge (count == period) it restarts at 1,
// loads the next period and on time, and advances the shift register.
// The output is high while count <= on time.
// Assumes duty_i and rand_mode_i are synchronous to clk.
module rand_period_pwm
    import prpwm_pkg::*;
#(
    parameter int          LW    = LFSR_W,
    parameter logic [LW-1:0] TAPS = LFSR_TAP,
    parameter logic [LW-1:0] SEED = LFSR_SEED,
    parameter int          NOM   = NOM_CNT,
    parameter int          BASE  = BASE_CNT,
    parameter int          SPAN  = SPAN_CNT,
    parameter int          DW    = DUTY_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] duty_i,
    input  logic          rand_mode_i,
    output logic          pwm_o
);
    localparam int PW = $clog2(((NOM > BASE + SPAN) ? NOM : BASE + SPAN) + 1);

    logic [PW-1:0] cnt_q, per_q, on_q;
    logic [PW-1:0] nxt_per, nxt_on;
    logic [LW-1:0] lfsr;
    logic          reload;

    // period boundary: last clock of the current period
    assign reload = (cnt_q == per_q);

    prpwm_lfsr #(.W(LW), .TAPS(TAPS), .SEED(SEED)) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv_i   (reload),
        .state_o (lfsr)
    );

    prpwm_period #(.LW(LW), .PW(PW), .NOM(NOM), .BASE(BASE), .SPAN(SPAN)) u_period (
        .lfsr_i   (lfsr),
        .rand_i   (rand_mode_i),
        .period_o (nxt_per)
    );

    prpwm_ontime #(.PW(PW), .DW(DW)) u_ontime (
        .period_i (nxt_per),
        .duty_i   (duty_i),
        .on_o     (nxt_on)
    );

    // cycle counter with period and on-time registers reloaded at the boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= PW'(1);
            per_q <= PW'(NOM);
            on_q  <= '0;
        end else if (reload) begin
            cnt_q <= PW'(1);
            per_q <= nxt_per;
            on_q  <= nxt_on;
        end else begin
            cnt_q <= cnt_q + PW'(1);
        end
    end

    // output: high for the first on_q counts of each period
    assign pwm_o = (cnt_q <= on_q);

    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q >= PW'(1)) && (cnt_q <= per_q));

    p_on_fit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        on_q <= per_q);

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !reload |=> ($stable(per_q) && $stable(on_q)));

    p_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reload && !rand_mode_i) |=> (per_q == PW'(NOM)));

    p_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reload && rand_mode_i) |=> ((per_q >= PW'(BASE)) && (per_q <= PW'(BASE + SPAN))));
endmodule

// File: tb/tb_rand_period_pwm.sv
// Scoreboard bench: the driver pushes the expected (period, on time)
// of each coming period into a queue. The monitor pops one item per
// period and compares the output cycle by cycle.
module tb_rand_period_pwm;
    typedef struct {
        int    per;
        int    hi;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] duty_i = 8'd0;
    logic       rand_mode_i = 1'b0;
    logic       pwm_o;

    int   n_chk = 0;
    int   n_fail = 0;
    bit   mon_en = 1'b0;
    bit   finished = 1'b0;
    exp_t sb_q[$];

    always #10 clk = ~clk;   // 50 MHz

    rand_period_pwm dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .duty_i      (duty_i),
        .rand_mode_i (rand_mode_i),
        .pwm_o       (pwm_o)
    );

    // ---------------- reference model ----------------
    logic [11:0] m_lfsr;

    function automatic logic [11:0] lfsr_step(input logic [11:0] s);
        return {s[10:0], s[11] ^ s[5] ^ s[3] ^ s[0]};
    endfunction

    function automatic int duty_for(input int k);
        case (k % 8)
            0: return 128;
            1: return 0;
            2: return 255;
            3: return 64;
            4: return 1;
            5: return 200;
            6: return 32;
            default: return 250;
        endcase
    endfunction

    // ---------------- monitor ----------------
    exp_t cur;
    int   left = 0, idx = 0, bad = 0, highs = 0, first_bad = -1, per_no = 0;

    always @(negedge clk) begin
        if (!mon_en) begin
            left = 0;
        end else begin
            if (left == 0 && sb_q.size() > 0) begin
                cur = sb_q.pop_front();
                left = cur.per; idx = 0; bad = 0; highs = 0; first_bad = -1;
                per_no++;
            end
            if (left > 0) begin
                if (pwm_o) highs++;
                if (pwm_o !== (idx < cur.hi)) begin
                    bad++;
                    if (first_bad < 0) first_bad = idx;
                end
                idx++; left--;
                if (left == 0) begin
                    n_chk++;
                    if (bad != 0) begin
                        n_fail++;
                        $display("FAIL %s: period #%0d actual highs=%0d first mismatch at clk %0d, expected P=%0d H=%0d",
                                 cur.tag, per_no, highs, first_bad, cur.per, cur.hi);
                    end
                end
            end
        end
    end

    // ---------------- driver ----------------
    task automatic session(input int n);
        int p_cur, p_nxt, h_nxt, d;
        bit r;
        string t;
        @(negedge clk); #1;
        rst_n = 1'b0; mon_en = 1'b0; duty_i = 8'd255; rand_mode_i = 1'b1;
        repeat (3) begin
            @(negedge clk);
            n_chk++;   // R1: output low while reset is held
            if (pwm_o !== 1'b0) begin
                n_fail++;
                $display("FAIL R1: pwm during reset actual=%b expected=0", pwm_o);
            end
        end
        #1;
        m_lfsr = 12'h5A5;
        sb_q.push_back('{per: 500, hi: 0, tag: "R1"});
        mon_en = 1'b1;
        @(negedge clk); #1;
        rst_n = 1'b1;
        p_cur = 500;
        for (int k = 1; k <= n; k++) begin
            // R4: junk values early in the period must not affect anything
            duty_i = ~duty_i; rand_mode_i = ~rand_mode_i;
            repeat (p_cur / 2) @(negedge clk);
            #1;
            p_nxt = p_cur;
            if (k < n) begin
                d = duty_for(k + 1);
                r = ((k + 1) % 16) >= 5;
                duty_i = 8'(d); rand_mode_i = r;
                p_nxt = r ? 375 + ((int'(m_lfsr) * 375) >> 12) : 500;
                h_nxt = (p_nxt * d) >> 8;
                m_lfsr = lfsr_step(m_lfsr);   // R7: advance every boundary
                if (d == 0 || d == 255) t = "R9/R3/R2";
                else if (r)             t = "R6/R7/R8/R3/R2/R4";
                else                    t = "R5/R3/R2/R4";
                sb_q.push_back('{per: p_nxt, hi: h_nxt, tag: t});
            end
            repeat (p_cur - p_cur / 2) @(negedge clk);
            #1;
            p_cur = p_nxt;
        end
        mon_en = 1'b0;
    endtask

    initial begin
        session(70);
        // mid-run reset: seed reload must reproduce the start-up sequence
        repeat (37) @(negedge clk);
        session(20);
        repeat (5) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule